// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This unit collects single-cycle event pulses from the command engine, the data engine, the FIFO and the card-detect logic of an SD host controller. It latches them into a 20-bit raw status register that software clears by writing ones. A mask register selects which latched events may interrupt the processor. The unit offers two read views: the raw register and the masked register. Software can therefore see errors it has chosen not to be interrupted by. One interrupt request line leaves the block. It is qualified by a global enable bit in a control register.

The card-detect pin is not taken as an event directly. It first passes a two-flop synchronizer. It then goes through a debouncer whose stable-time limit is a 24-bit programmable count. Only a level that has survived that time raises status bit 0, and both insertion and removal do so.

A software reset bit in the control register clears all latched status and puts the debouncer back to idle. The mask, the enable bit and the debounce count are not touched by it.

Top module: `sdirq_status_unit`

## Requirements
- R1: After reset, raw status, mask and control read 0, the debounce register reads 0x000FFFFF and irqOut is 0.
- R2: A pulse on evIn[i] sets raw status bit i+1 at the next clock edge, and the bit stays set until it is cleared. The bit map is: 1 response error, 2 command done, 3 data transfer over, 4 TX request, 5 RX request, 6 response CRC, 7 data CRC, 8 response timeout, 9 read timeout, 10 starvation timeout, 11 FIFO over/underrun, 12 locked error, 13 start-bit error, 14 auto-command done, 15 end-bit error, 19:16 SDIO.
- R3: Writing raw status (address 2) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R4: When an event pulse and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R5: Address 3 reads raw status AND mask (address 1, bits 19:0). A write to address 3 changes no register.
- R6: irqOut is 1 exactly when control bit 4 is 1 and the masked status is nonzero.
- R7: The debounce register (address 4) holds bits 23:0 as written; bits 31:24 read 0.
- R8: Raw bit 0 is set only after the synchronized card-detect level has differed from the last accepted level, and held steady, for more than the debounce count cycles. Rising and falling levels both count.
- R9: A change of pin level restarts the debounce count, so a pulse on the pin shorter than the count raises no event.
- R10: Writing control (address 0) with bit 0 set clears all raw status and makes the debouncer accept the present pin level without an event. Control bit 0 reads 0, and the mask and debounce count keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evIn | input | 19 | Event pulses for raw status bits 19:1 |
| cdPin | input | 1 | Raw, asynchronous card-detect pin |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address (0 ctrl, 1 mask, 2 raw, 3 masked, 4 debounce) |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational from regAddr) |
| irqOut | output | 1 | Interrupt request |

## Verification
The embedded assertions check the following on every cycle:
- that an event leaves its bit set after the edge;
- that a write clears the written bits that saw no event;
- that a software reset empties the status;
- that an interrupt never appears without a latched bit;
- that the debouncer restarts its count on any level change and accepts only the level it was watching.

The bench's scenarios are needed for the rest:
- the exact timing of a debounced card-detect event against the programmed count;
- rejection of a short pin glitch;
- events on both pin edges;
- the read-only nature of the masked view;
- random sequences of events, clears, mask and enable changes compared with a reference model.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;
  localparam int STAT_W  = 20;
  localparam int DATA_W  = 32;
  localparam int DB_W    = 24;
  localparam int ADDR_W  = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL     = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MASK     = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_RAW      = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_MASKED   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_DEBOUNCE = 3'd4;

  localparam int CTRL_SRST_BIT = 0;
  localparam int CTRL_IEN_BIT  = 4;

  localparam logic [DB_W-1:0] DB_RESET_VAL = 24'h0FFFFF;

  typedef struct packed {
    logic wrCtrl;
    logic wrMask;
    logic wrRaw;
    logic wrDeb;
    logic softRst;
  } strobe_t;
endpackage

// File: rtl/sdirq_ctrl.sv
module sdirq_ctrl
  import sdirq_pkg::*;
(
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              srstReq,
  output strobe_t           strb
);
  always_comb begin
    strb.wrCtrl  = regWe && (regAddr == ADDR_CTRL);
    strb.wrMask  = regWe && (regAddr == ADDR_MASK);
    strb.wrRaw   = regWe && (regAddr == ADDR_RAW);
    strb.wrDeb   = regWe && (regAddr == ADDR_DEBOUNCE);
    strb.softRst = regWe && (regAddr == ADDR_CTRL) && srstReq;
  end
endmodule

// File: rtl/sdirq_cd_debounce.sv
module sdirq_cd_debounce #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cdPin,
  input  logic             softRst,
  input  logic [CNT_W-1:0] limit,
  output logic             cdEvent
);
  logic syncA, syncB, prevLvl, stableLvl;
  logic [CNT_W-1:0] cnt;
  logic levelDiffers, levelSteady, fire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
    end else begin
      syncA <= cdPin;
      syncB <= syncA;
    end
  end

  assign levelDiffers = (syncB != stableLvl);
  assign levelSteady  = (syncB == prevLvl);
  assign fire         = levelDiffers && levelSteady && (cnt >= limit);
  assign cdEvent      = fire && !softRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLvl   <= 1'b0;
      stableLvl <= 1'b0;
      cnt       <= '0;
    end else begin
      prevLvl <= syncB;
      if (softRst) begin
        stableLvl <= syncB;
        cnt       <= '0;
      end else if (!levelDiffers || !levelSteady) begin
        cnt <= '0;
      end else if (fire) begin
        stableLvl <= syncB;
        cnt       <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R9: any level change restarts the count
  assert_change_restarts_R9: assert property (@(posedge clk) disable iff (!rstN)
    (syncB != prevLvl) |=> (cnt == '0));

  // R8: an event adopts the watched level and flips the accepted level
  assert_event_adopts_level_R8: assert property (@(posedge clk) disable iff (!rstN)
    cdEvent |=> ((stableLvl == $past(syncB)) && (stableLvl != $past(stableLvl))));

  // R10: soft reset returns to idle with a zero count
  assert_srst_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (cnt == '0));
endmodule

// File: rtl/sdirq_regs.sv
module sdirq_regs
  import sdirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic [STAT_W-1:0] evVec,
  output logic [DB_W-1:0]   dbLimit,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut
);
  logic [STAT_W-1:0] rawStat, maskReg, maskedStat, clrVec;
  logic ctrlIen;
  logic unusedWdata;

  assign unusedWdata = ^regWdata[DATA_W-1:DB_W];
  assign clrVec      = strb.wrRaw ? regWdata[STAT_W-1:0] : '0;
  assign maskedStat  = rawStat & maskReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rawStat <= '0;
      maskReg <= '0;
      ctrlIen <= 1'b0;
      dbLimit <= DB_RESET_VAL;
    end else begin
      if (strb.softRst) rawStat <= '0;
      else              rawStat <= (rawStat & ~clrVec) | evVec;
      if (strb.wrMask) maskReg <= regWdata[STAT_W-1:0];
      if (strb.wrCtrl) ctrlIen <= regWdata[CTRL_IEN_BIT];
      if (strb.wrDeb)  dbLimit <= regWdata[DB_W-1:0];
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_CTRL:     regRdata[CTRL_IEN_BIT] = ctrlIen;
      ADDR_MASK:     regRdata[STAT_W-1:0]   = maskReg;
      ADDR_RAW:      regRdata[STAT_W-1:0]   = rawStat;
      ADDR_MASKED:   regRdata[STAT_W-1:0]   = maskedStat;
      ADDR_DEBOUNCE: regRdata[DB_W-1:0]     = dbLimit;
      default:       regRdata = '0;
    endcase
  end

  assign irqOut = ctrlIen && (|maskedStat);

  // R2: an event leaves its bit set after the edge
  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((|evVec) && !strb.softRst) |=> ((rawStat & $past(evVec)) == $past(evVec)));

  // R3: written ones without a coinciding event are cleared
  assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrRaw |=> ((rawStat & $past(clrVec & ~evVec)) == '0));

  // R10: soft reset empties the status
  assert_srst_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.softRst |=> (rawStat == '0));

  // R6: no interrupt without a latched bit
  assert_irq_needs_pending_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (|rawStat));
endmodule

// File: rtl/sdirq_status_unit.sv
module sdirq_status_unit
  import sdirq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [STAT_W-2:0] evIn,
  input  logic              cdPin,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut
);
  strobe_t           strb;
  logic              cdEvent;
  logic [DB_W-1:0]   dbLimit;
  logic [STAT_W-1:0] evVec;

  assign evVec = {evIn, cdEvent};

  sdirq_ctrl ctrl_i (
    .regWe   (regWe),
    .regAddr (regAddr),
    .srstReq (regWdata[CTRL_SRST_BIT]),
    .strb    (strb)
  );

  sdirq_cd_debounce #(.CNT_W(DB_W)) deb_i (
    .clk     (clk),
    .rstN    (rstN),
    .cdPin   (cdPin),
    .softRst (strb.softRst),
    .limit   (dbLimit),
    .cdEvent (cdEvent)
  );

  sdirq_regs regs_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .evVec    (evVec),
    .dbLimit  (dbLimit),
    .regRdata (regRdata),
    .irqOut   (irqOut)
  );
endmodule

// File: tb/sdirq_status_unit_tb_top.sv
module sdirq_status_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [18:0] evIn = '0;
  logic        cdPin = 1'b0;
  logic        regWe = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic        irqOut;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [19:0] mRaw = '0;
  logic [19:0] mMask = '0;
  logic        mIen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdirq_status_unit dut_i (
    .clk(clk), .rstN(rstN), .evIn(evIn), .cdPin(cdPin), .regWe(regWe),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  function automatic logic [19:0] expMasked();
    return mRaw & mMask;
  endfunction

  function automatic logic expIrq();
    return mIen && (|(mRaw & mMask));
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  // one cycle with optional write and events driven together
  task automatic step(input logic we, input logic [2:0] a, input logic [31:0] d,
                      input logic [18:0] ev);
    @(negedge clk);
    regWe = we; regAddr = a; regWdata = d; evIn = ev;
    @(negedge clk);
    regWe = 1'b0; evIn = '0;
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    step(1'b1, a, d, '0);
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic checkAll(input string tag);
    logic [31:0] d;
    rdReg(3'd2, d); check({tag, " R2 raw"}, d, {12'b0, mRaw});
    rdReg(3'd3, d); check({tag, " R5 masked"}, d, {12'b0, expMasked()});
    check({tag, " R6 irq"}, {31'b0, irqOut}, {31'b0, expIrq()});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    waitCycles(3);
    rstN = 1'b1;
    waitCycles(2);

    // R1 reset values
    rdReg(3'd0, d); check("R1 ctrl", d, 32'h0);
    rdReg(3'd1, d); check("R1 mask", d, 32'h0);
    rdReg(3'd2, d); check("R1 raw", d, 32'h0);
    rdReg(3'd4, d); check("R1 debounce", d, 32'h000FFFFF);
    check("R1 irq", {31'b0, irqOut}, 32'h0);

    // R7 debounce width
    wrReg(3'd4, 32'hABCDEF12);
    rdReg(3'd4, d); check("R7 debounce bits", d, 32'h00CDEF12);

    // R2 single event, bit 3 (data transfer over) from evIn[2]
    step(1'b0, 3'd0, 32'h0, 19'h4); mRaw |= 20'h8;
    checkAll("single");
    // R3 clear with zeros then ones
    wrReg(3'd2, 32'h0); checkAll("R3 write0");
    wrReg(3'd2, 32'h8); mRaw = '0; checkAll("R3 write1");

    // R4 event and clear same cycle
    step(1'b1, 3'd2, 32'hFFFFF, 19'h1); mRaw = 20'h2;
    checkAll("R4 same cycle");
    rdReg(3'd2, d); check("R4 bit kept", d, 32'h2);

    // R5 masked is read-only
    wrReg(3'd1, 32'h2); mMask = 20'h2;
    wrReg(3'd3, 32'hFFFFF);
    rdReg(3'd1, d); check("R5 mask after masked write", d, 32'h2);
    checkAll("R5 ro");

    // R6 enable gating
    check("R6 irq disabled", {31'b0, irqOut}, 32'h0);
    wrReg(3'd0, 32'h10); mIen = 1'b1;
    check("R6 irq enabled", {31'b0, irqOut}, 32'h1);
    wrReg(3'd1, 32'h0); mMask = '0;
    check("R6 irq masked off", {31'b0, irqOut}, 32'h0);
    wrReg(3'd2, 32'hFFFFF); mRaw = '0;

    // random mix
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 3);
      logic [18:0] ev = ($urandom_range(0, 1) == 1) ? 19'($urandom) : 19'h0;
      logic [31:0] wd = $urandom;
      logic [2:0] a;
      logic we = 1'b1;
      case (op)
        0: begin a = 3'd2; end
        1: begin a = 3'd1; end
        2: begin a = 3'd0; wd[0] = 1'b0; end
        default: begin a = 3'd3; we = ($urandom_range(0, 1) == 1); end
      endcase
      step(we, a, wd, ev);
      if (we && a == 3'd2) mRaw = (mRaw & ~wd[19:0]) | {ev, 1'b0};
      else begin
        mRaw = mRaw | {ev, 1'b0};
        if (we && a == 3'd1) mMask = wd[19:0];
        if (we && a == 3'd0) mIen = wd[4];
      end
      checkAll("random");
    end

    // card detect tests
    wrReg(3'd1, 32'h0); mMask = '0;
    wrReg(3'd2, 32'hFFFFF); mRaw = '0;
    wrReg(3'd4, 32'd20);
    // R9 short glitch
    @(negedge clk); cdPin = 1'b1;
    waitCycles(15);
    cdPin = 1'b0;
    waitCycles(40);
    rdReg(3'd2, d); check("R9 glitch no event", d, 32'h0);
    // R8 rising
    @(negedge clk); cdPin = 1'b1;
    waitCycles(19);
    rdReg(3'd2, d); check("R8 not yet", d, 32'h0);
    waitCycles(12);
    rdReg(3'd2, d); check("R8 rising event", d, 32'h1);
    wrReg(3'd2, 32'h1);
    waitCycles(30);
    rdReg(3'd2, d); check("R8 single event", d, 32'h0);
    // R8 falling
    @(negedge clk); cdPin = 1'b0;
    waitCycles(35);
    rdReg(3'd2, d); check("R8 falling event", d, 32'h1);

    // R10 soft reset
    wrReg(3'd1, 32'h5);
    step(1'b0, 3'd0, 32'h0, 19'h7FFFF);
    @(negedge clk); cdPin = 1'b1;
    waitCycles(5);
    wrReg(3'd0, 32'h11);
    rdReg(3'd2, d); check("R10 raw cleared", d, 32'h0);
    rdReg(3'd0, d); check("R10 ctrl bit0 reads 0", d, 32'h10);
    rdReg(3'd1, d); check("R10 mask kept", d, 32'h5);
    rdReg(3'd4, d); check("R10 debounce kept", d, 32'd20);
    waitCycles(40);
    rdReg(3'd2, d); check("R10 debouncer idle", d, 32'h0);
    check("R10 irq low", {31'b0, irqOut}, 32'h0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule